// File: doc/BRIEF.md
# Sync-Triggered Stream Capture Buffer

This block records words from a valid-qualified input stream into an internal buffer RAM. Software first loads a delay and then arms the buffer with a register write. The next sync pulse on the stream starts an acquisition. Writing begins once the programmed number of valid input cycles has passed after that sync. The buffer then fills with consecutive valid words until it is full. It stays frozen until software arms it again.

Three status counters help software follow the stream. The first counts sync pulses and is cleared when the last buffer location is read. The second holds the number of words written by the current capture. The third counts valid cycles since the most recent sync. Software reads these counters through a small register port and reads the captured data through a separate RAM read port. Both ports have a fixed latency of one cycle.

Top module: `cap_buf_top`

## Requirements
- R1: After reset all status counters read 0, the delay register reads 0, the buffer is not armed, and `reg_rdata_o` and `ram_rdata_o` are 0.
- R2: A sync is a cycle with both `in_sync_i` and `in_valid_i` high. A register write to word index 2 arms the buffer. The first sync after arming starts a capture and consumes the arm. Syncs that arrive while the buffer is not armed write nothing.
- R3: Only cycles with `in_valid_i` high are stored and counted toward the delay. Data present on cycles with `in_valid_i` low never reaches the buffer.
- R4: With delay D (register word index 3), the first stored word is the valid word D valid cycles after the trigger sync. The sync word itself counts as position 0. Later words go to consecutive addresses starting at 0.
- R5: A capture stops after DEPTH words, and the word count then reads DEPTH. Later stream data and unarmed syncs leave the buffer unchanged.
- R6: The word count is cleared to 0 by the trigger sync of a new capture. Buffer locations not yet rewritten keep their older contents.
- R7: The valid count (read at word index 2) is set to 0 by each sync and increments on every later valid cycle. A sync qualifier seen on a non-valid cycle does not clear it.
- R8: The sync count (word index 0) increments on each sync. It is cleared by a RAM read of address DEPTH-1, and the clear wins if both happen in the same cycle.
- R9: A register read returns data on `reg_rdata_o` one cycle after `reg_rd_i`. The word indices are: 0 sync count, 1 word count, 2 valid count, 3 delay, 7 the VERSION parameter. Any other index reads 0. `reg_rdata_o` holds its value between reads.
- R10: A RAM read returns the word stored at `ram_addr_i` on `ram_rdata_o` one cycle after `ram_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Stream word valid |
| in_sync_i | input | 1 | Stream sync marker, qualified by valid |
| in_data_i | input | DATA_W | Stream data word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| ram_rd_i | input | 1 | Buffer read strobe |
| ram_addr_i | input | ADDR_W | Buffer read address |
| ram_rdata_o | output | DATA_W | Buffer read data, one cycle after the strobe |

## Verification
Stream effects on the counters and the buffer take hold at the clock edge that samples the stream cycle. Register and RAM reads then take one more edge before their data appears. The bench drives every stimulus at a falling edge. It records a pending flag for each read at the following rising edge, and its monitor compares at the next falling edge, which is exactly one cycle after the strobe. Expected buffer contents come from a running sequence number that the bench puts only on valid cycles. The stored address of each word therefore follows from the sync position, the delay and the depth alone.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CAPT} cap_state_e;

  localparam int unsigned REG_W = 32;
  localparam logic [2:0] IDX_SYNC  = 3'd0;
  localparam logic [2:0] IDX_WORDS = 3'd1;
  localparam logic [2:0] IDX_VALID = 3'd2;  // read: valid count, write: arm
  localparam logic [2:0] IDX_DELAY = 3'd3;
  localparam logic [2:0] IDX_VER   = 3'd7;
endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end

  a_r10_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/cap_stat.sv
module cap_stat #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sync_i,     // already qualified by valid
  input  logic             last_rd_i,
  output logic [CNT_W-1:0] sync_cnt_o,
  output logic [CNT_W-1:0] valid_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_cnt_o  <= '0;
      valid_cnt_o <= '0;
    end else begin
      if (last_rd_i)   sync_cnt_o <= '0;   // clear wins over a coincident sync
      else if (sync_i) sync_cnt_o <= sync_cnt_o + 1'b1;
      if (sync_i)       valid_cnt_o <= '0;
      else if (valid_i) valid_cnt_o <= valid_cnt_o + 1'b1;
    end
  end

  a_r8_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_rd_i |=> sync_cnt_o == '0);
  a_r7_valid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> valid_cnt_o == '0);
  a_r7_valid_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sync_i) |=> valid_cnt_o == $past(valid_cnt_o) + 1'b1);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned CW     = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sync_i,
  input  logic              arm_i,
  input  logic [REG_W-1:0]  delay_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CW-1:0]     word_cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
  localparam bit ONE_DEEP = (DEPTH == 1);

  cap_state_e       state_q;
  logic             armed_q;
  logic [REG_W-1:0] dly_cnt_q;
  logic [CW-1:0]    word_cnt_q;
  logic             trig;

  assign trig = (state_q == ST_IDLE) && armed_q && sync_i;

  always_comb begin
    wr_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: wr_en_o = trig && (delay_i == '0);
      ST_WAIT: wr_en_o = valid_i && (dly_cnt_q == delay_i);
      ST_CAPT: wr_en_o = valid_i;
      default: wr_en_o = 1'b0;
    endcase
  end

  assign wr_addr_o  = (state_q == ST_CAPT) ? word_cnt_q[ADDR_W-1:0] : '0;
  assign word_cnt_o = word_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      armed_q    <= 1'b0;
      dly_cnt_q  <= '0;
      word_cnt_q <= '0;
    end else begin
      if (arm_i)     armed_q <= 1'b1;
      else if (trig) armed_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (trig) begin
          if (wr_en_o) begin
            word_cnt_q <= CW'(1);
            state_q    <= ONE_DEEP ? ST_IDLE : ST_CAPT;
          end else begin
            word_cnt_q <= '0;
            dly_cnt_q  <= REG_W'(1);
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: if (wr_en_o) begin
          word_cnt_q <= CW'(1);
          state_q    <= ONE_DEEP ? ST_IDLE : ST_CAPT;
        end else if (valid_i) begin
          dly_cnt_q <= dly_cnt_q + 1'b1;
        end
        ST_CAPT: if (wr_en_o) begin
          word_cnt_q <= word_cnt_q + 1'b1;
          if (word_cnt_q == LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_word_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt_q <= CW'(DEPTH));
  a_r2_arm_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !arm_i) |=> !armed_q);
  a_r6_trig_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && delay_i != '0) |=> word_cnt_q == '0);
  a_r5_idle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !trig) |=> $stable(word_cnt_q));
endmodule

// File: rtl/cap_buf_top.sv
module cap_buf_top
  import cap_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h0000_0001,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sync_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ram_rd_i,
  input  logic [ADDR_W-1:0] ram_addr_i,
  output logic [DATA_W-1:0] ram_rdata_o
);
  localparam int unsigned CW = ADDR_W + 1;

  logic              sync_v, arm, last_rd, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CW-1:0]     word_cnt;
  logic [CNT_W-1:0]  sync_cnt, valid_cnt;
  logic [REG_W-1:0]  delay_q;

  assign sync_v  = in_sync_i && in_valid_i;
  assign arm     = reg_wr_i && (reg_addr_i == IDX_VALID);
  assign last_rd = ram_rd_i && (ram_addr_i == ADDR_W'(DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) delay_q <= '0;
    else if (reg_wr_i && reg_addr_i == IDX_DELAY) delay_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (reg_rd_i) begin
      unique case (reg_addr_i)
        IDX_SYNC:  reg_rdata_o <= 32'(sync_cnt);
        IDX_WORDS: reg_rdata_o <= 32'(word_cnt);
        IDX_VALID: reg_rdata_o <= 32'(valid_cnt);
        IDX_DELAY: reg_rdata_o <= delay_q;
        IDX_VER:   reg_rdata_o <= VERSION;
        default:   reg_rdata_o <= '0;
      endcase
    end
  end

  cap_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CW(CW)) i_ctrl (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .sync_i(sync_v), .arm_i(arm), .delay_i(delay_q),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .word_cnt_o(word_cnt)
  );

  cap_stat #(.CNT_W(CNT_W)) i_stat (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .sync_i(sync_v), .last_rd_i(last_rd),
    .sync_cnt_o(sync_cnt), .valid_cnt_o(valid_cnt)
  );

  cap_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ram (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(in_data_i),
    .rd_en_i(ram_rd_i), .rd_addr_i(ram_addr_i), .rd_data_o(ram_rdata_o)
  );

  a_r9_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == IDX_VER) |=> reg_rdata_o == VERSION);
  a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
  a_r3_wr_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> in_valid_i);
endmodule

// File: tb/test_cap_buf_top.sv
module test_cap_buf_top;
  localparam int unsigned DW    = 32;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam logic [31:0] VER   = 32'h0000_0A17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sync = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ram_rd = 1'b0;
  logic [AW-1:0] ram_addr = '0;
  logic [DW-1:0] ram_rdata;

  always #10 clk = ~clk;  // 50 MHz

  cap_buf_top #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(32), .VERSION(VER)) i_cap_buf_top (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sync_i(in_sync), .in_data_i(in_data),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ram_rd_i(ram_rd), .ram_addr_i(ram_addr), .ram_rdata_o(ram_rdata)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int unsigned seq = 100;

  logic [31:0] reg_exp_q[$];
  string       reg_tag_q[$];
  logic [31:0] ram_exp_q[$];
  string       ram_tag_q[$];
  logic        reg_pend_q = 1'b0, ram_pend_q = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", tag, act, act, exp, exp);
    end
  endtask

  always @(posedge clk) begin
    reg_pend_q <= reg_rd;
    ram_pend_q <= ram_rd;
  end

  // monitor: results are due one cycle after each strobe
  always @(negedge clk) begin
    if (reg_pend_q && reg_exp_q.size() > 0)
      check(reg_tag_q.pop_front(), reg_rdata, reg_exp_q.pop_front());
    if (ram_pend_q && ram_exp_q.size() > 0)
      check(ram_tag_q.pop_front(), ram_rdata, ram_exp_q.pop_front());
  end

  // all driver tasks start and end at a falling edge
  task automatic tick(bit v, bit s);
    in_valid = v;
    in_sync  = s;
    in_data  = v ? DW'(seq) : 32'hBAD0_0000 | DW'(seq);
    @(negedge clk);
    if (v) seq++;
    in_valid = 1'b0;
    in_sync  = 1'b0;
  endtask

  task automatic reg_write(logic [2:0] idx, logic [31:0] val);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] idx, logic [31:0] exp, string tag);
    reg_exp_q.push_back(exp);
    reg_tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = idx;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ram_read(int unsigned a, logic [31:0] exp, string tag);
    ram_exp_q.push_back(exp);
    ram_tag_q.push_back(tag);
    ram_rd = 1'b1; ram_addr = AW'(a);
    @(negedge clk);
    ram_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned s0, s1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reg_rdata after reset", reg_rdata, 32'd0);
    check("R1 ram_rdata after reset", ram_rdata, 32'd0);
    reg_read(3'd0, 0, "R1 sync count");
    reg_read(3'd1, 0, "R1 word count");
    reg_read(3'd2, 0, "R1 valid count");
    reg_read(3'd3, 0, "R1 delay");
    reg_read(3'd7, VER, "R9 version");
    reg_read(3'd5, 0, "R9 unmapped index");

    // unarmed syncs, one sync marker on an invalid cycle
    tick(1, 0); tick(1, 1); tick(1, 0); tick(0, 1);
    tick(1, 1); tick(1, 0); tick(1, 0);
    reg_read(3'd1, 0, "R2 unarmed syncs write nothing");
    reg_read(3'd0, 2, "R8 sync count");
    reg_read(3'd2, 2, "R7 valid count since sync");

    // delay 0 capture, fills the buffer with gaps in valid
    reg_write(3'd3, 0);
    reg_write(3'd2, 32'h1);
    tick(1, 0); tick(1, 0);
    s0 = seq;
    tick(1, 1);
    for (int i = 0; i < 20; i++) begin
      tick(1, 0);
      if (i % 3 == 0) tick(0, 0);
    end
    reg_read(3'd1, DEPTH, "R5 word count full");
    reg_read(3'd0, 3, "R8 sync count before clear");
    reg_read(3'd2, 20, "R7 valid count");
    ram_read(0, s0, "R2 first word is sync word");
    ram_read(5, s0 + 5, "R3 invalid cycles skipped");
    ram_read(DEPTH - 1, s0 + DEPTH - 1, "R10 last address");
    reg_read(3'd0, 0, "R8 cleared by last-word read");

    // unarmed sync after full capture
    tick(1, 1); tick(1, 0); tick(1, 0); tick(1, 0);
    ram_read(0, s0, "R5 buffer frozen");
    reg_read(3'd1, DEPTH, "R5 word count held");

    // delay 3 capture
    reg_write(3'd3, 3);
    reg_read(3'd3, 3, "R9 delay readback");
    reg_write(3'd2, 32'h0);
    s1 = seq;
    tick(1, 1); tick(0, 0); tick(1, 0); tick(1, 0);
    reg_read(3'd1, 0, "R6 word count cleared by trigger");
    tick(1, 0); tick(0, 0); tick(1, 0);
    reg_read(3'd1, 2, "R4 two words after delay");
    ram_read(0, s1 + 3, "R4 first word after delay");
    ram_read(1, s1 + 4, "R3 second word after gap");
    ram_read(2, s0 + 2, "R6 older word kept");
    reg_read(3'd2, 4, "R7 valid count after new sync");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule